// File: doc/BRIEF.md
# Receive Interrupt Mode Controller

This block decides when one serial receive channel asks the processor for attention. It watches the character-available flag of the receive FIFO, the error flags that travel with the word at the FIFO head, and an overrun pulse from the deserializer. A two-bit mode input selects one of three behaviours: no receive interrupts, a single request for the first character that arrives after the mode is chosen (re-armable by command), or a request whenever a character is waiting. Special receive conditions raise a separate request in either active mode. Which conditions count depends on the mode, the framing protocol (asynchronous or bit-oriented) and whether parity checking is on.

The block also keeps parity and overrun errors in sticky latches. It reports them, ORed with the errors of the current head word, as a four-bit status nibble that fills the upper half of the channel's status byte. In first-character mode, a head word with a special condition freezes FIFO reads through a hold output until software issues an error reset. The FIFO storage and the deserializer sit outside this block.

Top module: `rx_irq_ctrl`

## Requirements
- R1: While reset is applied, and in the first cycle after it with all inputs low, `irq_char`, `irq_special` and `fifo_hold` are 0 and `err_status` is 4'b0000.
- R2: `rx_mode` encodings are 2'b00 off, 2'b01 first-character, 2'b10 all-characters and 2'b11 off. In both off encodings, `irq_char`, `irq_special` and `fifo_hold` stay 0 whatever the other inputs do.
- R3: In all-characters mode, `irq_char` equals `char_avail` in every cycle.
- R4: In first-character mode, `irq_char` is high for exactly one cycle. That cycle is the first one with `char_avail` high after the mode was entered (the entry cycle included). Further characters raise no `irq_char`.
- R5: `cmd_arm_next` in first-character mode re-arms it from the next cycle on. The next cycle with `char_avail` high then raises `irq_char` again.
- R6: In first-character mode, `irq_special` is the OR of three terms: latched overrun; head framing error while `proto_bitsync`=0; head end-of-frame while `proto_bitsync`=1. Head terms count only when `char_avail`=1. Parity never contributes.
- R7: In all-characters mode, `irq_special` is the first-character condition set plus parity, counted when `par_chk_en`=1 and either latched parity or the head word's parity flag (with `char_avail`) is set.
- R8: `ovr_pulse` sets the overrun latch, and a head parity error (with `char_avail`) sets the parity latch. Each shows in `err_status` from the next cycle on. Only `cmd_err_reset` clears them, one cycle later. A new event in the same cycle as the reset wins and stays latched.
- R9: `err_status` bit 3 is head end-of-frame, bit 2 is head framing error (both gated by `char_avail`), bit 1 is latched overrun, and bit 0 is latched parity ORed with the current head parity flag.
- R10: `fifo_hold` is 0 outside first-character mode. Inside it, `fifo_hold` goes high in the same cycle as an `ovr_pulse` or a head special condition (as in R6). It stays high until a cycle with `cmd_err_reset` and no `ovr_pulse`; in that cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_mode | input | 2 | Receive interrupt mode (see R2) |
| proto_bitsync | input | 1 | 0 asynchronous framing, 1 bit-oriented framing |
| par_chk_en | input | 1 | Parity checking enable |
| char_avail | input | 1 | Receive FIFO holds at least one word |
| head_par_err | input | 1 | Parity error flag of the head word |
| head_frm_err | input | 1 | Framing error flag of the head word |
| head_eof | input | 1 | End-of-frame flag of the head word |
| ovr_pulse | input | 1 | One-cycle receive overrun event |
| cmd_arm_next | input | 1 | Command strobe: interrupt on next character |
| cmd_err_reset | input | 1 | Command strobe: error reset |
| irq_char | output | 1 | Receive character interrupt request |
| irq_special | output | 1 | Special receive condition interrupt request |
| fifo_hold | output | 1 | Blocks reads of the receive FIFO |
| err_status | output | 4 | Error nibble {eof, framing, overrun, parity} |

## Verification
A stuck or lost arm flag shows up in the first cycle with `char_avail` high after entering first-character mode or after a re-arm command: `irq_char` is either missing or repeats. A wrong sticky latch shows in `err_status` bits 1 and 0 one cycle after an overrun, a parity event or an error reset. In all-characters mode it also shows on `irq_special`, and the same-cycle reset/event collision is what exposes a wrong clear priority. A hold latch that clears early or fails to release shows on `fifo_hold` within one cycle, either after the triggering condition is removed from the head or in the error-reset cycle.

// File: rtl/rxi_pkg.sv
package rxi_pkg;

  typedef enum logic [1:0] {
    RXI_OFF   = 2'b00,
    RXI_FIRST = 2'b01,
    RXI_ALL   = 2'b10,
    RXI_OFF_B = 2'b11
  } rxi_mode_e;

  localparam int ERR_W   = 4;
  localparam int ERR_EOF = 3;
  localparam int ERR_FRM = 2;
  localparam int ERR_OVR = 1;
  localparam int ERR_PAR = 0;

  // head word condition that matters in both active modes
  function automatic logic head_special(input logic avail, input logic frm,
                                        input logic eof, input logic bitsync);
    return avail & ((frm & ~bitsync) | (eof & bitsync));
  endfunction

  // sticky bit next state: a new event beats a clear
  function automatic logic sticky_next(input logic evt, input logic clr,
                                       input logic q);
    if (evt) return 1'b1;
    if (clr) return 1'b0;
    return q;
  endfunction

  function automatic logic [ERR_W-1:0] pack_status(input logic eof, input logic frm,
                                                  input logic ovr, input logic par);
    logic [ERR_W-1:0] s;
    s = '0;
    s[ERR_EOF] = eof;
    s[ERR_FRM] = frm;
    s[ERR_OVR] = ovr;
    s[ERR_PAR] = par;
    return s;
  endfunction

endpackage

// File: rtl/rxi_arm.sv
module rxi_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic first_mode,
  input  logic char_avail,
  input  logic cmd_arm,
  output logic irq_first
);
  logic was_first_q;
  logic armed_q;
  logic entering;
  logic armed_eff;
  logic armed_d;

  assign entering  = first_mode & ~was_first_q;
  assign armed_eff = armed_q | entering;
  assign irq_first = first_mode & armed_eff & char_avail;

  always_comb begin
    if (!first_mode)    armed_d = 1'b0;
    else if (cmd_arm)   armed_d = 1'b1;
    else if (irq_first) armed_d = 1'b0;
    else                armed_d = armed_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_first_q <= 1'b0;
      armed_q     <= 1'b0;
    end else begin
      was_first_q <= first_mode;
      armed_q     <= armed_d;
    end
  end

  // R4
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_first && !cmd_arm) |=> !irq_first);

  // R5
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_mode && cmd_arm) |=> (!first_mode || !char_avail || irq_first));

endmodule

// File: rtl/rxi_sticky.sv
module rxi_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic par_evt,
  input  logic ovr_evt,
  input  logic clr,
  output logic par_q,
  output logic ovr_q
);
  import rxi_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      par_q <= sticky_next(par_evt, clr, par_q);
      ovr_q <= sticky_next(ovr_evt, clr, ovr_q);
    end
  end

  // R8
  ovr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_q);

  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ovr_evt) |=> !ovr_q);

  // R8
  par_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_evt |=> par_q);

  // R8
  par_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_q && !clr) |=> par_q);

endmodule

// File: rtl/rxi_hold.sv
module rxi_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic first_mode,
  input  logic head_spec,
  input  logic ovr_evt,
  input  logic clr,
  output logic hold
);
  logic hold_q;
  logic hold_d;

  always_comb begin
    if (!first_mode) hold_d = 1'b0;
    else if (ovr_evt) hold_d = 1'b1;
    else if (clr)     hold_d = 1'b0;
    else              hold_d = hold_q | head_spec;
  end

  // same-cycle view: the hold blocks the read that would pop the bad word
  assign hold = hold_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  // R10
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !first_mode |-> !hold);

  // R10
  hold_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_mode && ovr_evt) |-> hold);

  // R10
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> (hold || !first_mode || clr));

  // R10
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ovr_evt) |-> !hold);

endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_mode,
  input  logic       proto_bitsync,
  input  logic       par_chk_en,
  input  logic       char_avail,
  input  logic       head_par_err,
  input  logic       head_frm_err,
  input  logic       head_eof,
  input  logic       ovr_pulse,
  input  logic       cmd_arm_next,
  input  logic       cmd_err_reset,
  output logic       irq_char,
  output logic       irq_special,
  output logic       fifo_hold,
  output logic [3:0] err_status
);
  import rxi_pkg::*;

  rxi_mode_e mode;
  logic      mode_first;
  logic      mode_all;
  logic      irq_first;
  logic      par_now;
  logic      par_q;
  logic      ovr_q;
  logic      head_spec;
  logic      spec_base;
  logic      spec_par;

  assign mode       = rxi_mode_e'(rx_mode);
  assign mode_first = (mode == RXI_FIRST);
  assign mode_all   = (mode == RXI_ALL);

  assign par_now   = char_avail & head_par_err;
  assign head_spec = head_special(char_avail, head_frm_err, head_eof, proto_bitsync);
  assign spec_base = ovr_q | head_spec;
  assign spec_par  = par_chk_en & (par_q | par_now);

  rxi_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .first_mode (mode_first),
    .char_avail (char_avail),
    .cmd_arm    (cmd_arm_next),
    .irq_first  (irq_first)
  );

  rxi_sticky u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .par_evt (par_now),
    .ovr_evt (ovr_pulse),
    .clr     (cmd_err_reset),
    .par_q   (par_q),
    .ovr_q   (ovr_q)
  );

  rxi_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .first_mode (mode_first),
    .head_spec  (head_spec),
    .ovr_evt    (ovr_pulse),
    .clr        (cmd_err_reset),
    .hold       (fifo_hold)
  );

  always_comb begin
    unique case (mode)
      RXI_FIRST: begin
        irq_char    = irq_first;
        irq_special = spec_base;
      end
      RXI_ALL: begin
        irq_char    = char_avail;
        irq_special = spec_base | spec_par;
      end
      default: begin
        irq_char    = 1'b0;
        irq_special = 1'b0;
      end
    endcase
  end

  assign err_status = pack_status(char_avail & head_eof, char_avail & head_frm_err,
                                  ovr_q, par_q | par_now);

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_first && !mode_all) |-> (!irq_char && !irq_special && !fifo_hold));

  // R6
  first_no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_first && !err_status[ERR_OVR] && !err_status[ERR_FRM] && !err_status[ERR_EOF])
      |-> !irq_special);

  // R8
  ovr_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_pulse |=> err_status[ERR_OVR]);

  // R3
  all_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_all && !char_avail) |-> !irq_char);

endmodule

// File: tb/rx_irq_ctrl_tb.sv
module rx_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 4000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rx_mode = 2'b00;
  logic       proto_bitsync = 1'b0, par_chk_en = 1'b0, char_avail = 1'b0;
  logic       head_par_err = 1'b0, head_frm_err = 1'b0, head_eof = 1'b0;
  logic       ovr_pulse = 1'b0, cmd_arm_next = 1'b0, cmd_err_reset = 1'b0;
  logic       irq_char, irq_special, fifo_hold;
  logic [3:0] err_status;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .proto_bitsync(proto_bitsync),
    .par_chk_en(par_chk_en), .char_avail(char_avail), .head_par_err(head_par_err),
    .head_frm_err(head_frm_err), .head_eof(head_eof), .ovr_pulse(ovr_pulse),
    .cmd_arm_next(cmd_arm_next), .cmd_err_reset(cmd_err_reset),
    .irq_char(irq_char), .irq_special(irq_special), .fifo_hold(fifo_hold),
    .err_status(err_status)
  );

  // reference state, built from the requirements
  logic m_ovr, m_par, m_arm, m_hold;
  logic [1:0] m_prev;

  function automatic logic is_first(input logic [1:0] m); return m == 2'b01; endfunction
  function automatic logic is_all(input logic [1:0] m);   return m == 2'b10; endfunction

  function automatic logic hd_cond();
    if (!char_avail) return 1'b0;
    return proto_bitsync ? head_eof : head_frm_err;
  endfunction

  function automatic logic arm_now();
    return m_arm || (is_first(rx_mode) && !is_first(m_prev));
  endfunction

  function automatic logic exp_char();
    if (is_all(rx_mode))   return char_avail;
    if (is_first(rx_mode)) return char_avail && arm_now();
    return 1'b0;
  endfunction

  function automatic logic exp_spec();
    logic base;
    base = m_ovr || hd_cond();
    if (is_first(rx_mode)) return base;
    if (is_all(rx_mode))
      return base || (par_chk_en && (m_par || (char_avail && head_par_err)));
    return 1'b0;
  endfunction

  function automatic logic exp_hold();
    if (!is_first(rx_mode)) return 1'b0;
    if (ovr_pulse) return 1'b1;
    if (cmd_err_reset) return 1'b0;
    return m_hold || hd_cond();
  endfunction

  function automatic logic [3:0] exp_status();
    return {char_avail && head_eof, char_avail && head_frm_err, m_ovr,
            m_par || (char_avail && head_par_err)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ovr <= 1'b0; m_par <= 1'b0; m_arm <= 1'b0; m_hold <= 1'b0; m_prev <= 2'b00;
    end else begin
      m_hold <= exp_hold();
      m_ovr  <= ovr_pulse ? 1'b1 : (cmd_err_reset ? 1'b0 : m_ovr);
      m_par  <= (char_avail && head_par_err) ? 1'b1 : (cmd_err_reset ? 1'b0 : m_par);
      if (!is_first(rx_mode))          m_arm <= 1'b0;
      else if (cmd_arm_next)           m_arm <= 1'b1;
      else if (char_avail && arm_now()) m_arm <= 1'b0;
      else                             m_arm <= arm_now();
      m_prev <= rx_mode;
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    string ct;
    ct = is_all(rx_mode) ? "R3 irq_char" : (is_first(rx_mode) ? "R4 irq_char" : "R2 irq_char");
    chk(ct, {3'b0, irq_char}, {3'b0, exp_char()});
    chk(is_all(rx_mode) ? "R7 irq_special" : (is_first(rx_mode) ? "R6 irq_special" : "R2 irq_special"),
        {3'b0, irq_special}, {3'b0, exp_spec()});
    chk("R10 fifo_hold", {3'b0, fifo_hold}, {3'b0, exp_hold()});
    chk("R9 err_status head", {2'b0, err_status[3:2]}, {2'b0, exp_status()[3:2]});
    chk("R8 err_status sticky", {2'b0, err_status[1:0]}, {2'b0, exp_status()[1:0]});
  endtask

  task automatic idle();
    char_avail = 0; head_par_err = 0; head_frm_err = 0; head_eof = 0;
    ovr_pulse = 0; cmd_arm_next = 0; cmd_err_reset = 0;
  endtask

  // drive at negedge, check 2 time units later, model advances at posedge
  task automatic step();
    #2 chk_all();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1 reset outputs", {1'b0, irq_char, irq_special, fifo_hold}, 4'b0000);
    chk("R1 reset status", err_status, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {1'b0, irq_char, irq_special, fifo_hold}, 4'b0000);

    // R2: off mode ignores everything
    rx_mode = 2'b11; char_avail = 1; head_frm_err = 1; ovr_pulse = 1; par_chk_en = 1;
    #2 chk("R2 off encoding 11", {1'b0, irq_char, irq_special, fifo_hold}, 4'b0000);
    @(negedge clk); idle(); cmd_err_reset = 1; step(); idle();

    // R4 / R5: first-character mode, one shot and re-arm
    rx_mode = 2'b01; step();
    char_avail = 1;
    #2 chk("R4 first char irq", {3'b0, irq_char}, 4'b0001);
    @(negedge clk);
    #2 chk("R4 no second irq", {3'b0, irq_char}, 4'b0000);
    @(negedge clk); cmd_arm_next = 1; step(); cmd_arm_next = 0;
    #2 chk("R5 rearmed irq", {3'b0, irq_char}, 4'b0001);
    @(negedge clk); idle();

    // R8: reset and new overrun in same cycle, event wins
    ovr_pulse = 1; step(); ovr_pulse = 1; cmd_err_reset = 1; step(); idle();
    #2 chk("R8 event beats reset", {3'b0, err_status[1]}, 4'b0001);
    @(negedge clk); cmd_err_reset = 1; step(); idle();
    #2 chk("R8 cleared", {3'b0, err_status[1]}, 4'b0000);
    @(negedge clk);

    // R10: framing error holds, error reset releases
    proto_bitsync = 0; char_avail = 1; head_frm_err = 1; step(); idle();
    #2 chk("R10 hold latched", {3'b0, fifo_hold}, 4'b0001);
    @(negedge clk); cmd_err_reset = 1;
    #2 chk("R10 release on reset", {3'b0, fifo_hold}, 4'b0000);
    @(negedge clk); idle();

    // R7: parity in all mode
    rx_mode = 2'b10; par_chk_en = 1; char_avail = 1; head_par_err = 1;
    #2 chk("R7 parity special", {3'b0, irq_special}, 4'b0001);
    @(negedge clk); idle(); cmd_err_reset = 1; step(); idle();

    for (int i = 0; i < N_RANDOM; i++) begin
      if ($urandom_range(31) == 0) rx_mode = 2'($urandom_range(3));
      if ($urandom_range(63) == 0) proto_bitsync = ~proto_bitsync;
      if ($urandom_range(63) == 0) par_chk_en = ~par_chk_en;
      char_avail    = $urandom_range(1);
      head_par_err  = ($urandom_range(3) == 0);
      head_frm_err  = ($urandom_range(3) == 0);
      head_eof      = ($urandom_range(3) == 0);
      ovr_pulse     = ($urandom_range(15) == 0);
      cmd_arm_next  = ($urandom_range(15) == 0);
      cmd_err_reset = ($urandom_range(7) == 0);
      step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule